// File: doc/BRIEF.md
# Multi-Mailbox Message Reassembly Unit

This block sits between a serial packet fabric and an Ethernet transmit path. Message segments arrive one per cycle, each tagged with a mailbox number, a letter number, the index of the segment inside its group and the index of the group's final segment. The mailbox and letter fields together select one of sixteen independent reassembly contexts. Each context keeps its segments in a shared segment store, records which indices have arrived in an arrival bitmap and holds back its group until every index from zero up to the recorded final index is present.

Complete groups are handed to a round-robin arbiter. The chosen group is sent out as a contiguous burst of data beats in index order, with the context number and an end-of-frame marker beside the data. A context that stays partly filled too long is discarded and flagged, so that the sender can send the whole group again. Bad segments are dropped and flagged.

Top module: `mbx_reassembly`

## Requirements
- R1: No beat of a group is sent until every segment index from 0 up to its recorded final index has been accepted.
- R2: The context number is `{in_mbox, in_letter}` (mailbox field in the upper bits). The sixteen contexts fill independently and the data of one never appears in the frame of another.
- R3: A context's final index is taken from the `in_len` field of the first segment it accepts. The `in_len` field of later segments to that context is ignored until the context is cleared.
- R4: A segment whose index is above the context's final index is dropped (the final index is the segment's own `in_len` when the context is empty). `err_drop` is high for one cycle, in the cycle after the segment.
- R5: A segment whose index has already arrived replaces the stored data for that index and neither completes nor un-completes the group.
- R6: A frame is `final index + 1` beats on consecutive cycles, in ascending index order. `out_ctx` is constant for the whole frame, `out_last` is high on the final beat only, and at least one idle cycle follows each frame.
- R7: When several contexts are complete, the arbiter grants the first complete context found by counting upward, with wrap-around, from the context granted last. After reset, counting starts at context 0.
- R8: A partly filled context that accepts no segment for `TMO_CYC` consecutive cycles is discarded. Its bit in `err_tmo` is high for one cycle and no beat of it is ever sent.
- R9: After a frame has been sent, or after a timeout, the context's bitmap and final index are cleared, so the next segment to it starts a new group.
- R10: A segment sent to a context whose group is complete is dropped with `err_drop`, and the frame keeps its stored data.
- R11: While and right after reset, `out_valid`, `out_last`, `err_drop` and `err_tmo` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A segment is present this cycle |
| in_mbox | input | MBOX_W | Mailbox field, upper part of the context number |
| in_letter | input | LTR_W | Letter field, lower part of the context number |
| in_len | input | IDX_W | Index of the group's final segment |
| in_idx | input | IDX_W | Index of this segment |
| in_data | input | DATA_W | Segment payload word |
| out_valid | output | 1 | Frame beat valid |
| out_ctx | output | MBOX_W+LTR_W | Context the frame came from |
| out_data | output | DATA_W | Frame beat payload |
| out_last | output | 1 | Final beat of the frame |
| err_drop | output | 1 | A segment was dropped in the previous cycle |
| err_tmo | output | 2^(MBOX_W+LTR_W) | One bit per context, pulsed when that context times out |

## Verification
The bench delivers groups out of order, and checks that nothing leaves early and that beats come out sorted by index. A design that forwarded on arrival, or tested only the newest bit, would send a frame before it was whole. Duplicates and out-of-range indices are sent, and the length field is changed on later segments, to catch a design that counts arrivals rather than testing the bitmap or that re-reads the length on every segment. Three contexts are completed while a long frame is going out, which tells round-robin order from fixed priority. A completed context is written to while it is being sent, and contexts are reused after a send and after a timeout, which exposes stale bitmaps, stale lengths and a timer that fires too early.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [0:0] {
    EMIT_IDLE = 1'b0,
    EMIT_SEND = 1'b1
  } emit_st_t;
endpackage

// File: rtl/mbx_seg_store.sv
module mbx_seg_store #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/mbx_ctx_track.sv
module mbx_ctx_track #(
  parameter int CTX_W   = 4,
  parameter int IDX_W   = 4,
  parameter int TMO_CYC = 1024
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               seg_vld,
  input  logic [CTX_W-1:0]                   seg_ctx,
  input  logic [IDX_W-1:0]                   seg_idx,
  input  logic [IDX_W-1:0]                   seg_len,
  input  logic                               clr_vld,
  input  logic [CTX_W-1:0]                   clr_ctx,
  output logic [(1<<CTX_W)-1:0]              done_vec,
  output logic [(1<<CTX_W)-1:0][IDX_W-1:0]   rec_len,
  output logic [(1<<CTX_W)-1:0]              acc_vec,
  output logic [(1<<CTX_W)-1:0]              tmo_vec
);
  localparam int NCTX  = 1 << CTX_W;
  localparam int NSEG  = 1 << IDX_W;
  localparam int TMO_W = $clog2(TMO_CYC + 1);
  localparam logic [TMO_W-1:0] AGE_END = TMO_W'(TMO_CYC - 1);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NSEG - 1);

  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    logic [NSEG-1:0]  bmap;
    logic [IDX_W-1:0] len_q;
    logic [TMO_W-1:0] age;
    logic [NSEG-1:0]  need;
    logic [IDX_W-1:0] eff_len;
    logic             open_q, full, partial, hit, acc, tmo, clr;

    assign open_q  = |bmap;
    assign need    = {NSEG{1'b1}} >> (TOP_IDX - len_q);
    assign full    = open_q && (bmap == need);
    assign partial = open_q && !full;
    assign hit     = seg_vld && (seg_ctx == CTX_W'(c));
    assign eff_len = open_q ? len_q : seg_len;
    assign acc     = hit && !full && (seg_idx <= eff_len);
    assign tmo     = partial && !acc && (age == AGE_END);
    assign clr     = clr_vld && (clr_ctx == CTX_W'(c));

    always_ff @(posedge clk) begin
      if (rst || clr || tmo) begin
        bmap  <= '0;
        len_q <= '0;
        age   <= '0;
      end else if (acc) begin
        bmap[seg_idx] <= 1'b1;
        len_q         <= eff_len;
        age           <= '0;
      end else if (partial) begin
        age <= age + 1'b1;
      end
    end

    assign done_vec[c] = full;
    assign rec_len[c]  = len_q;
    assign acc_vec[c]  = acc;
    assign tmo_vec[c]  = tmo;
  end
endmodule

// File: rtl/mbx_rr_arb.sv
module mbx_rr_arb #(
  parameter int W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [(1<<W)-1:0]   req,
  input  logic                take,
  output logic                gnt_any,
  output logic [W-1:0]        gnt_idx
);
  localparam int N = 1 << W;

  logic [W-1:0] ptr;
  logic [W-1:0] probe;

  always_comb begin
    gnt_any = 1'b0;
    gnt_idx = '0;
    probe   = '0;
    for (int k = 1; k <= N; k++) begin
      probe = ptr + W'(k);
      if (!gnt_any && req[probe]) begin
        gnt_any = 1'b1;
        gnt_idx = probe;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                  ptr <= W'(N - 1);
    else if (take && gnt_any) ptr <= gnt_idx;
  end
endmodule

// File: rtl/mbx_reassembly.sv
module mbx_reassembly #(
  parameter int DATA_W  = 32,
  parameter int MBOX_W  = 2,
  parameter int LTR_W   = 2,
  parameter int IDX_W   = 4,
  parameter int TMO_CYC = 1024
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              in_valid,
  input  logic [MBOX_W-1:0]                 in_mbox,
  input  logic [LTR_W-1:0]                  in_letter,
  input  logic [IDX_W-1:0]                  in_len,
  input  logic [IDX_W-1:0]                  in_idx,
  input  logic [DATA_W-1:0]                 in_data,
  output logic                              out_valid,
  output logic [MBOX_W+LTR_W-1:0]           out_ctx,
  output logic [DATA_W-1:0]                 out_data,
  output logic                              out_last,
  output logic                              err_drop,
  output logic [(1<<(MBOX_W+LTR_W))-1:0]    err_tmo
);
  import mbx_pkg::*;

  localparam int CTX_W  = MBOX_W + LTR_W;
  localparam int NCTX   = 1 << CTX_W;
  localparam int ADDR_W = CTX_W + IDX_W;

  logic [CTX_W-1:0]             seg_ctx;
  logic [NCTX-1:0]              done_vec, acc_vec, tmo_vec;
  logic [NCTX-1:0][IDX_W-1:0]   rec_len;
  logic                         wr_en, seg_drop;
  logic                         gnt_any;
  logic [CTX_W-1:0]             gnt_idx;

  emit_st_t                     state;
  logic [CTX_W-1:0]             cur_ctx;
  logic [IDX_W-1:0]             cur_seg, cur_len;
  logic                         rd_en, clr_vld, take;

  assign seg_ctx  = {in_mbox, in_letter};
  assign wr_en    = |acc_vec;
  assign seg_drop = in_valid && !wr_en;

  mbx_ctx_track #(
    .CTX_W(CTX_W), .IDX_W(IDX_W), .TMO_CYC(TMO_CYC)
  ) u_track (
    .clk(clk), .rst(rst),
    .seg_vld(in_valid), .seg_ctx(seg_ctx), .seg_idx(in_idx), .seg_len(in_len),
    .clr_vld(clr_vld), .clr_ctx(cur_ctx),
    .done_vec(done_vec), .rec_len(rec_len), .acc_vec(acc_vec), .tmo_vec(tmo_vec)
  );

  mbx_seg_store #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_store (
    .clk(clk),
    .we(wr_en), .waddr({seg_ctx, in_idx}), .wdata(in_data),
    .re(rd_en), .raddr({cur_ctx, cur_seg}), .rdata(out_data)
  );

  mbx_rr_arb #(
    .W(CTX_W)
  ) u_arb (
    .clk(clk), .rst(rst),
    .req(done_vec), .take(take),
    .gnt_any(gnt_any), .gnt_idx(gnt_idx)
  );

  always_comb begin
    rd_en   = (state == EMIT_SEND);
    clr_vld = rd_en && (cur_seg == cur_len);
    take    = (state == EMIT_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= EMIT_IDLE;
      cur_ctx   <= '0;
      cur_seg   <= '0;
      cur_len   <= '0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_ctx   <= '0;
      err_drop  <= 1'b0;
      err_tmo   <= '0;
    end else begin
      out_valid <= rd_en;
      out_last  <= clr_vld;
      if (rd_en) out_ctx <= cur_ctx;
      err_drop  <= seg_drop;
      err_tmo   <= tmo_vec;
      case (state)
        EMIT_IDLE: begin
          if (gnt_any) begin
            cur_ctx <= gnt_idx;
            cur_len <= rec_len[gnt_idx];
            cur_seg <= '0;
            state   <= EMIT_SEND;
          end
        end
        EMIT_SEND: begin
          if (clr_vld) state <= EMIT_IDLE;
          else         cur_seg <= cur_seg + 1'b1;
        end
        default: state <= EMIT_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mbx_reassembly_chk.sv
module mbx_reassembly_chk #(
  parameter int CTX_W = 4,
  parameter int NCTX  = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             out_valid,
  input logic             out_last,
  input logic [CTX_W-1:0] out_ctx,
  input logic             err_drop,
  input logic [NCTX-1:0]  err_tmo
);
  // R11
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_last && !err_drop && err_tmo == '0));

  // R6
  beat_run_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_last) |=> (out_valid && $stable(out_ctx)));

  // R6
  frame_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_last) |=> !out_valid);

  // R6
  last_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);

  // R4
  drop_cause_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !err_drop);

  // R8
  tmo_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (err_tmo != '0) |=> ((err_tmo & $past(err_tmo)) == '0));
endmodule

bind mbx_reassembly mbx_reassembly_chk #(
  .CTX_W(CTX_W), .NCTX(NCTX)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid),
  .out_valid(out_valid), .out_last(out_last), .out_ctx(out_ctx),
  .err_drop(err_drop), .err_tmo(err_tmo)
);

// File: tb/tb_mbx_reassembly.sv
module tb_mbx_reassembly;
  localparam int DW  = 32;
  localparam int TMO = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [1:0] in_mbox = '0, in_letter = '0;
  logic [3:0] in_len = '0, in_idx = '0;
  logic [DW-1:0] in_data = '0;
  logic out_valid, out_last, err_drop;
  logic [3:0] out_ctx;
  logic [DW-1:0] out_data;
  logic [15:0] err_tmo;

  mbx_reassembly #(.DATA_W(DW), .MBOX_W(2), .LTR_W(2), .IDX_W(4), .TMO_CYC(TMO)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_mbox(in_mbox), .in_letter(in_letter),
    .in_len(in_len), .in_idx(in_idx), .in_data(in_data),
    .out_valid(out_valid), .out_ctx(out_ctx), .out_data(out_data), .out_last(out_last),
    .err_drop(err_drop), .err_tmo(err_tmo)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // frame capture
  int fr_n = 0, bi = 0, drop_cnt = 0;
  logic [3:0] fr_ctx [64];
  int fr_len [64];
  logic [DW-1:0] fr_w [64][16];
  logic [15:0] tmo_mask = '0;

  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid && fr_n < 64) begin
        if (bi < 16) fr_w[fr_n][bi] = out_data;
        bi = bi + 1;
        if (out_last) begin
          fr_ctx[fr_n] = out_ctx;
          fr_len[fr_n] = bi;
          fr_n = fr_n + 1;
          bi = 0;
        end
      end
      if (err_drop) drop_cnt = drop_cnt + 1;
      tmo_mask = tmo_mask | err_tmo;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic send_seg(input logic [3:0] ctx, input logic [3:0] len,
                          input logic [3:0] idx, input logic [DW-1:0] d);
    in_mbox = ctx[3:2]; in_letter = ctx[1:0];
    in_len = len; in_idx = idx; in_data = d; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk(out_valid == 1'b0, "R11", "out_valid after reset", out_valid, 0);
    chk(err_drop == 1'b0, "R11", "err_drop after reset", err_drop, 0);
    chk(err_tmo == '0, "R11", "err_tmo after reset", err_tmo, 0);
  endtask

  task automatic t_single();
    int b = fr_n;
    send_seg(4'h6, 4'd0, 4'd0, 32'hA0A0_0001);
    idle(6);
    chk(fr_n == b + 1, "R6", "single frame count", fr_n - b, 1);
    chk(fr_ctx[b] == 4'h6, "R2", "single ctx from mbox/letter", fr_ctx[b], 6);
    chk(fr_len[b] == 1, "R6", "single beats", fr_len[b], 1);
    chk(fr_w[b][0] == 32'hA0A0_0001, "R6", "single data", fr_w[b][0], 32'hA0A0_0001);
  endtask

  task automatic t_order();
    int b = fr_n;
    send_seg(4'hB, 4'd3, 4'd2, 32'hB2);
    send_seg(4'hB, 4'd3, 4'd0, 32'hB0);
    send_seg(4'hB, 4'd3, 4'd3, 32'hB3);
    idle(6);
    chk(fr_n == b, "R1", "partial group held", fr_n - b, 0);
    send_seg(4'hB, 4'd3, 4'd1, 32'hB1);
    idle(8);
    chk(fr_n == b + 1 && fr_ctx[b] == 4'hB, "R6", "ordered frame ctx", fr_ctx[b], 4'hB);
    chk(fr_len[b] == 4, "R6", "ordered frame beats", fr_len[b], 4);
    for (int i = 0; i < 4; i++)
      chk(fr_w[b][i] == 32'hB0 + i, "R6", "index order", fr_w[b][i], 32'hB0 + i);
  endtask

  task automatic t_interleave();
    int b = fr_n;
    send_seg(4'h1, 4'd1, 4'd0, 32'h10);
    send_seg(4'h4, 4'd1, 4'd1, 32'h41);
    send_seg(4'h4, 4'd1, 4'd0, 32'h40);
    send_seg(4'h1, 4'd1, 4'd1, 32'h11);
    idle(10);
    chk(fr_n == b + 2, "R2", "two frames", fr_n - b, 2);
    chk(fr_ctx[b] == 4'h4 && fr_w[b][0] == 32'h40 && fr_w[b][1] == 32'h41,
        "R2", "ctx4 frame unmixed", fr_w[b][1], 32'h41);
    chk(fr_ctx[b+1] == 4'h1 && fr_w[b+1][0] == 32'h10 && fr_w[b+1][1] == 32'h11,
        "R2", "ctx1 frame unmixed", fr_w[b+1][1], 32'h11);
  endtask

  task automatic t_range();
    int b = fr_n;
    int d0 = drop_cnt;
    send_seg(4'h2, 4'd1, 4'd0, 32'h20);
    send_seg(4'h2, 4'd5, 4'd3, 32'h2F);
    idle(2);
    chk(drop_cnt == d0 + 1, "R4", "index above recorded length dropped", drop_cnt - d0, 1);
    send_seg(4'h2, 4'd7, 4'd1, 32'h21);
    idle(8);
    chk(fr_n == b + 1 && fr_len[b] == 2, "R3", "later length field ignored", fr_len[b], 2);
    chk(fr_w[b][1] == 32'h21, "R4", "dropped data absent", fr_w[b][1], 32'h21);
    send_seg(4'h8, 4'd1, 4'd2, 32'h82);
    idle(2);
    chk(drop_cnt == d0 + 2, "R4", "empty ctx index above own length", drop_cnt - d0, 2);
    send_seg(4'h8, 4'd0, 4'd0, 32'h80);
    idle(6);
    chk(fr_n == b + 2 && fr_len[b+1] == 1 && fr_w[b+1][0] == 32'h80,
        "R4", "empty ctx untouched by drop", fr_len[b+1], 1);
  endtask

  task automatic t_dup();
    int b = fr_n;
    send_seg(4'hD, 4'd2, 4'd0, 32'hD1);
    send_seg(4'hD, 4'd2, 4'd0, 32'hD2);
    send_seg(4'hD, 4'd2, 4'd1, 32'hE1);
    idle(6);
    chk(fr_n == b, "R5", "duplicate does not complete", fr_n - b, 0);
    send_seg(4'hD, 4'd2, 4'd2, 32'hE2);
    idle(8);
    chk(fr_n == b + 1 && fr_len[b] == 3, "R5", "frame after dup beats", fr_len[b], 3);
    chk(fr_w[b][0] == 32'hD2, "R5", "dup overwrote data", fr_w[b][0], 32'hD2);
  endtask

  task automatic t_rr();
    int b = fr_n;
    int d0 = drop_cnt;
    for (int i = 0; i < 16; i++) send_seg(4'h7, 4'd15, 4'(i), 32'h700 + i);
    send_seg(4'h3, 4'd0, 4'd0, 32'h300);
    send_seg(4'hC, 4'd0, 4'd0, 32'hC00);
    send_seg(4'h9, 4'd0, 4'd0, 32'h900);
    send_seg(4'h7, 4'd15, 4'd0, 32'hBAD);
    idle(40);
    chk(drop_cnt == d0 + 1, "R10", "segment to complete ctx dropped", drop_cnt - d0, 1);
    chk(fr_n == b + 4, "R7", "four frames", fr_n - b, 4);
    chk(fr_ctx[b] == 4'h7 && fr_len[b] == 16, "R6", "long frame", fr_len[b], 16);
    chk(fr_w[b][0] == 32'h700, "R10", "sealed frame data kept", fr_w[b][0], 32'h700);
    chk(fr_w[b][15] == 32'h70F, "R6", "long frame last word", fr_w[b][15], 32'h70F);
    chk(fr_ctx[b+1] == 4'h9, "R7", "rr grant after 7", fr_ctx[b+1], 9);
    chk(fr_ctx[b+2] == 4'hC, "R7", "rr grant after 9", fr_ctx[b+2], 12);
    chk(fr_ctx[b+3] == 4'h3, "R7", "rr grant wraps", fr_ctx[b+3], 3);
  endtask

  task automatic t_timeout();
    int b = fr_n;
    send_seg(4'h5, 4'd1, 4'd0, 32'h50);
    idle(TMO - 3);
    chk(tmo_mask == '0, "R8", "no early timeout", tmo_mask, 0);
    idle(10);
    chk(tmo_mask == 16'h0020, "R8", "timeout flag ctx5", tmo_mask, 16'h0020);
    chk(fr_n == b, "R8", "timed-out group not sent", fr_n - b, 0);
    send_seg(4'h5, 4'd1, 4'd1, 32'h61);
    idle(6);
    chk(fr_n == b, "R9", "bitmap cleared after timeout", fr_n - b, 0);
    send_seg(4'h5, 4'd1, 4'd0, 32'h60);
    idle(8);
    chk(fr_n == b + 1 && fr_w[b][0] == 32'h60 && fr_w[b][1] == 32'h61,
        "R9", "regathered group", fr_w[b][0], 32'h60);
  endtask

  task automatic t_reuse();
    int b = fr_n;
    int d0 = drop_cnt;
    send_seg(4'h6, 4'd1, 4'd1, 32'h71);
    idle(6);
    chk(drop_cnt == d0 && fr_n == b, "R9", "ctx reused after send, new length", drop_cnt - d0, 0);
    send_seg(4'h6, 4'd1, 4'd0, 32'h70);
    idle(8);
    chk(fr_n == b + 1 && fr_len[b] == 2 && fr_ctx[b] == 4'h6, "R9", "reused ctx frame", fr_len[b], 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    t_reset();
    @(negedge clk);
    t_single();
    t_order();
    t_interleave();
    t_range();
    t_dup();
    t_rr();
    t_timeout();
    t_reuse();
    idle(4);
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule